// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block paces the scanlines of a tile-based LCD controller. Each clock it may receive a step of up to `MAX_STEP` dot cycles, as an instruction-stepped core reports them, and it walks each visible line through three phases: sprite-table search, pixel transfer and horizontal blank. After the last visible line it holds the line counter in a run of vertical-blank lines and then wraps back to line 0. It reports the current phase, the current line, a one-clock strobe telling the renderer that a line's transfer phase has just finished, and a vertical-blank interrupt request flag.

Phase lengths are counted in an accumulator that keeps its remainder. When a step carries the count past the end of a phase, the excess cycles are credited to the next phase and are not lost. Over many lines the total stays exact, whatever the step size. The interrupt flag sits beside the timing logic. Software can write it either way and the interrupt controller can acknowledge it. The sequencer sets it whenever vertical blank begins.

Top module: `lcd_scan_seq`

## Requirements
- R1: After reset, `mode_o` is 2 (search), `line_o` is 0, `render_o` is 0, `vblank_irq_o` is 0 and the cycle accumulator is empty.
- R2: A clock with `step_valid_i` low changes neither `mode_o` nor `line_o` nor the accumulator, whatever `step_cycles_i` holds. A valid step of 0 cycles changes nothing either. Valid steps never exceed `MAX_STEP` (24).
- R3: `mode_o` encodes 0 horizontal blank, 1 vertical blank, 2 search, 3 transfer. Search lasts 80 cycles and is followed by transfer (3).
- R4: Transfer lasts 172 cycles and is then followed by horizontal blank (0). `render_o` is high for exactly the one clock in which `mode_o` first shows 0 after transfer, and it is low at all other times.
- R5: Horizontal blank lasts 204 cycles, and at its end `line_o` increments. After lines 0 to 142 the next phase is search (2). After line 143 it is vertical blank (1), with `line_o` at 144.
- R6: A phase ends in the step where the accumulated count reaches or passes its length. The accumulator then keeps the count minus the length, so the excess counts toward the next phase.
- R7: Each vertical-blank line lasts 456 cycles. `line_o` runs from 144 through 153. When line 153 ends, `line_o` becomes 0 and `mode_o` becomes 2.
- R8: `vblank_irq_o` goes high in the same clock in which `mode_o` becomes 1, and this takes priority over a write or an acknowledge in that clock.
- R9: When no vertical blank begins, `irq_wr_i` loads `vblank_irq_o` from `irq_wr_val_i`. Otherwise `irq_ack_i` clears the flag. A write takes priority over an acknowledge in the same clock. These inputs act whether or not a step is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid_i | input | 1 | Step enable for this clock |
| step_cycles_i | input | 5 | Dot cycles in this step, 0 to 24 |
| irq_wr_i | input | 1 | Software write to the interrupt flag |
| irq_wr_val_i | input | 1 | Value written to the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| mode_o | output | 2 | Current phase: 0 hblank, 1 vblank, 2 search, 3 transfer |
| line_o | output | 8 | Current line, 0 to 153 |
| render_o | output | 1 | One-clock strobe at the end of transfer |
| vblank_irq_o | output | 1 | Vertical-blank interrupt request |

## Verification
Two things can happen in the same clock: the entry into vertical blank, which raises the flag, and a software acknowledge or a write of 0 to that flag. The bench's reference model predicts the exact step that ends horizontal blank on line 143. In that step it drives an acknowledge, and in a later frame it drives a write of 0 in the same step. The flag is expected to read 1 in both cases, and it must then clear on a separate acknowledge. A write of 1 combined with an acknowledge is expected to leave the flag set.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_OAM    = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
    import lcd_seq_pkg::*;
#(
    parameter int OAM_CYCLES  = 80,
    parameter int XFER_CYCLES = 172,
    parameter int HBL_CYCLES  = 204,
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154,
    parameter int MAX_STEP    = 24
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 step_valid_i,
    input  logic [$clog2(MAX_STEP+1)-1:0]        step_cycles_i,
    output lcd_mode_e                            mode_o,
    output logic [$clog2(TOTAL_LINES)-1:0]       line_o,
    output logic                                 render_o,
    output logic                                 enter_vbl_o
);
    localparam int LINE_CYCLES = OAM_CYCLES + XFER_CYCLES + HBL_CYCLES;
    localparam int ACC_W       = $clog2(LINE_CYCLES + MAX_STEP + 1);
    localparam int LINE_W      = $clog2(TOTAL_LINES);

    typedef struct packed {
        lcd_mode_e          mode;
        logic [ACC_W-1:0]   acc;
        logic [LINE_W-1:0]  line;
        logic               render;
    } phase_st_t;

    phase_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] limit;
    logic             enter_vbl;

    function automatic logic [ACC_W-1:0] phase_len(lcd_mode_e m);
        case (m)
            MODE_OAM:    return ACC_W'(OAM_CYCLES);
            MODE_XFER:   return ACC_W'(XFER_CYCLES);
            MODE_HBLANK: return ACC_W'(HBL_CYCLES);
            default:     return ACC_W'(LINE_CYCLES);
        endcase
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.render = 1'b0;
        enter_vbl = 1'b0;
        sum       = st_q.acc + ACC_W'(step_cycles_i);
        limit     = phase_len(st_q.mode);
        if (step_valid_i) begin
            if (sum >= limit) begin
                st_d.acc = sum - limit;   // remainder carries into next phase
                case (st_q.mode)
                    MODE_OAM: st_d.mode = MODE_XFER;
                    MODE_XFER: begin
                        st_d.mode   = MODE_HBLANK;
                        st_d.render = 1'b1;
                    end
                    MODE_HBLANK: begin
                        st_d.line = st_q.line + 1'b1;
                        if (st_q.line == LINE_W'(VIS_LINES - 1)) begin
                            st_d.mode = MODE_VBLANK;
                            enter_vbl = 1'b1;
                        end else begin
                            st_d.mode = MODE_OAM;
                        end
                    end
                    default: begin
                        if (st_q.line == LINE_W'(TOTAL_LINES - 1)) begin
                            st_d.line = '0;
                            st_d.mode = MODE_OAM;
                        end else begin
                            st_d.line = st_q.line + 1'b1;
                        end
                    end
                endcase
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OAM, acc: '0, line: '0, render: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o      = st_q.mode;
    assign line_o      = st_q.line;
    assign render_o    = st_q.render;
    assign enter_vbl_o = enter_vbl;

    assert_step_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_i |-> (int'(step_cycles_i) <= MAX_STEP));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_valid_i |=> ($stable(st_q.mode) && $stable(st_q.line) && $stable(st_q.acc)));

    assert_acc_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < phase_len(st_q.mode));

    assert_strobe_hblank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.render |-> (st_q.mode == MODE_HBLANK));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.render |=> !st_q.render);

    assert_line_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.line) < TOTAL_LINES);

    assert_vbl_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_VBLANK) == (int'(st_q.line) >= VIS_LINES));

endmodule

// File: rtl/lcd_vbl_flag.sv
module lcd_vbl_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic wr_i,
    input  logic wr_val_i,
    input  logic ack_i,
    output logic irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (raise_i)     irq_d = 1'b1;
        else if (wr_i)   irq_d = wr_val_i;
        else if (ack_i)  irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    assert_raise_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i |=> irq_q);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !wr_i && !raise_i) |=> !irq_q);

    assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !raise_i) |=> (irq_q == $past(wr_val_i)));

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_seq_pkg::*;
#(
    parameter int OAM_CYCLES  = 80,
    parameter int XFER_CYCLES = 172,
    parameter int HBL_CYCLES  = 204,
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154,
    parameter int MAX_STEP    = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              step_valid_i,
    input  logic [$clog2(MAX_STEP+1)-1:0]     step_cycles_i,
    input  logic                              irq_wr_i,
    input  logic                              irq_wr_val_i,
    input  logic                              irq_ack_i,
    output logic [1:0]                        mode_o,
    output logic [$clog2(TOTAL_LINES)-1:0]    line_o,
    output logic                              render_o,
    output logic                              vblank_irq_o
);
    lcd_mode_e mode;
    logic      enter_vbl;

    lcd_phase_ctrl #(
        .OAM_CYCLES  (OAM_CYCLES),
        .XFER_CYCLES (XFER_CYCLES),
        .HBL_CYCLES  (HBL_CYCLES),
        .VIS_LINES   (VIS_LINES),
        .TOTAL_LINES (TOTAL_LINES),
        .MAX_STEP    (MAX_STEP)
    ) i_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_valid_i  (step_valid_i),
        .step_cycles_i (step_cycles_i),
        .mode_o        (mode),
        .line_o        (line_o),
        .render_o      (render_o),
        .enter_vbl_o   (enter_vbl)
    );

    lcd_vbl_flag i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise_i  (enter_vbl),
        .wr_i     (irq_wr_i),
        .wr_val_i (irq_wr_val_i),
        .ack_i    (irq_ack_i),
        .irq_o    (vblank_irq_o)
    );

    assign mode_o = mode;

endmodule

// File: tb/test_lcd_scan_seq.sv
`timescale 1ns/1ps
module test_lcd_scan_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_valid = 1'b0;
    logic [4:0] step_cycles = '0;
    logic       irq_wr = 1'b0, irq_wr_val = 1'b0, irq_ack = 1'b0;
    logic [1:0] mode;
    logic [7:0] line;
    logic       render, irq;

    always #2 clk = ~clk;   // 250 MHz

    lcd_scan_seq i_lcd_scan_seq (
        .clk(clk), .rst_n(rst_n), .step_valid_i(step_valid), .step_cycles_i(step_cycles),
        .irq_wr_i(irq_wr), .irq_wr_val_i(irq_wr_val), .irq_ack_i(irq_ack),
        .mode_o(mode), .line_o(line), .render_o(render), .vblank_irq_o(irq)
    );

    typedef struct { int mode; int line; int render; int irq; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    string cur_tag = "R1";
    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int m_acc = 0, m_mode = 2, m_line = 0;
    bit m_irq = 0;

    function automatic int len_of(int md);
        case (md)
            2: return 80;
            3: return 172;
            0: return 204;
            default: return 456;
        endcase
    endfunction

    function automatic bit will_enter(int cyc);
        return (m_mode == 0) && (m_line == 143) && (m_acc + cyc >= 204);
    endfunction

    task automatic check(string tg, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tg, what, act, expv);
        end
    endtask

    task automatic drive(bit v, int cyc, bit wr, bit wv, bit ack);
        exp_t e;
        int s;
        bit enter = 0;
        @(negedge clk);
        step_valid = v; step_cycles = 5'(cyc);
        irq_wr = wr; irq_wr_val = wv; irq_ack = ack;
        e.render = 0;
        if (v) begin
            s = m_acc + cyc;
            if (s >= len_of(m_mode)) begin
                m_acc = s - len_of(m_mode);
                case (m_mode)
                    2: m_mode = 3;
                    3: begin m_mode = 0; e.render = 1; end
                    0: begin
                        m_line++;
                        if (m_line == 144) begin m_mode = 1; enter = 1; end
                        else m_mode = 2;
                    end
                    default: begin
                        if (m_line == 153) begin m_line = 0; m_mode = 2; end
                        else m_line++;
                    end
                endcase
            end else begin
                m_acc = s;
            end
        end
        if (enter) m_irq = 1;
        else if (wr) m_irq = wv;
        else if (ack) m_irq = 0;
        e.mode = m_mode; e.line = m_line; e.irq = m_irq;
        exp_q.push_back(e);
        tag_q.push_back(cur_tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                check(tg, "mode", int'(mode), e.mode);
                check(tg, "line", int'(line), e.line);
                check(tg, "render", int'(render), e.render);
                check(tg, "irq", int'(irq), e.irq);
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "mode", int'(mode), 2);
        check("R1", "line", int'(line), 0);
        check("R1", "render", int'(render), 0);
        check("R1", "irq", int'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle clocks and zero steps change nothing
        cur_tag = "R2";
        for (int i = 0; i < 5; i++) drive(0, 24, 0, 0, 0);
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0);

        // R3 / R6: search ends when 80 reached; excess 12 carries into transfer
        cur_tag = "R6";
        for (int i = 0; i < 3; i++) drive(1, 24, 0, 0, 0);   // 72
        drive(1, 20, 0, 0, 0);                                 // 92 -> transfer, acc 12
        for (int i = 0; i < 6; i++) drive(1, 24, 0, 0, 0);   // 156
        drive(1, 15, 0, 0, 0);                                 // 171, still transfer
        drive(0, 24, 0, 0, 0);
        drive(1, 1, 0, 0, 0);                                  // exactly 172 -> hblank, R4 strobe
        drive(1, 0, 0, 0, 0);

        // R3 R4 R5: remainder of frame with full steps, line sequencing
        cur_tag = "R5";
        while (!(m_mode == 1)) drive(1, 24, 0, 0, 0);
        // R8 raise observed on entry above; clear with ack (R9)
        cur_tag = "R9";
        drive(0, 0, 0, 0, 1);
        // R7: vertical blank lines and wrap to 0
        cur_tag = "R7";
        while (!(m_mode == 2 && m_line == 0)) drive(1, 24, 0, 0, 0);
        drive(1, 24, 0, 0, 0);

        // R3: mixed step sizes and gaps across a whole frame (R4 R5 R6 R7 also)
        cur_tag = "R3";
        for (int i = 0; i < 9000; i++) drive((i % 4) != 3, (i * 7) % 25, 0, 0, 0);

        // R8: vertical blank entry coincides with acknowledge
        cur_tag = "R8";
        while (!will_enter(24)) drive(1, 24, 0, 0, 0);
        drive(1, 24, 0, 0, 1);
        cur_tag = "R9";
        drive(1, 24, 0, 0, 1);         // ack alone clears
        drive(0, 0, 1, 1, 1);          // write 1 beats ack
        drive(0, 0, 1, 0, 0);          // write 0 clears
        drive(1, 5, 1, 1, 0);          // write 1 sets during a step
        drive(0, 0, 0, 0, 1);

        // R8: entry coincides with a write of 0
        cur_tag = "R8";
        while (!will_enter(24)) drive(1, 24, 0, 0, 0);
        drive(1, 24, 1, 0, 0);
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule